// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single PWM command into two gate enables for a synchronous buck half-bridge: one for the high-side switch and one for the low-side switch. The two are never on together. Dead time is adaptive rather than fixed. Each hand-over waits for a sensed comparator flag before the incoming switch is enabled. When the high side turns off, the low side is enabled once the phase node is seen low.

If the phase node never drops, the low side is forced on after a refresh window so the bootstrap supply stays charged. If the phase node then stays high for a longer fault window, the low side is dropped. Both gates are then held off until the next PWM rising edge.

All sensing arrives as single-bit comparator flags:
- supply-good, from a hysteretic monitor;
- low-gate-below-threshold;
- phase-below-threshold;
- a flag saying the PWM input sits in its mid-level (tri-state) window.

Each flag passes through a synchronizer. Holding the tri-state flag for a holdoff time shuts both gates off until the flag clears. A two-bit status reports the operating condition. All windows are counted in clock cycles, derived from a clock-frequency parameter.

Top module: `deadtime_sequencer`

## Requirements
- R1: While supply-good is low, `hs_en` and `ls_en` are 0 and `mode` is 0 (idle); PWM edges and all other flags have no effect.
- R2: After supply-good returns, both gates stay off and `mode` stays 0 until a PWM edge arrives; a rising edge then starts normal sequencing (`mode` 1).
- R3: A PWM rising edge turns `ls_en` off. `hs_en` turns on only after the synchronized low-gate-below-threshold flag is high, never in the same cycle as `ls_en`, and never directly after a cycle with `ls_en` high.
- R4: A PWM falling edge turns `hs_en` off. `ls_en` turns on once the synchronized phase-below-threshold flag is high.
- R5: If the phase flag stays low, `ls_en` turns on REFRESH cycles after `hs_en` turned off. REFRESH is CLK_MHZ*REFRESH_NS/1000, which is 25 by default.
- R6: If the phase flag is still low FAULT cycles after `hs_en` turned off, `ls_en` goes off and `mode` becomes 3 (fault). FAULT is CLK_MHZ*FAULT_NS/1000, which is 200 by default. If the phase flag rises before then, no fault occurs.
- R7: In fault, both gates stay off and `mode` stays 3 regardless of the phase flag, until a PWM rising edge restarts sequencing.
- R8: When the synchronized tri-state flag stays high for HOLDOFF_CYC consecutive cycles (16 by default), both gates go off and `mode` becomes 2. A shorter stay has no effect.
- R9: While `mode` is 2, PWM edges are ignored. When the tri-state flag clears, sequencing resumes from the PWM level: high starts the turn-on step, low starts the high-off wait.
- R10: A PWM edge arriving mid-sequence restarts the sequence at its turn-off step, and the refresh and fault windows restart from the new high-side turn-off.
- R11: Each input change reaches the outputs three clock edges after it is applied: two synchronizer stages plus the registered outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM command, asynchronous |
| tri_win | input | 1 | PWM sits in its mid-level window |
| lg_low | input | 1 | Low gate has fallen below its threshold |
| ph_low | input | 1 | Phase node is below its threshold |
| supply_ok | input | 1 | Hysteretic supply-good flag |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| mode | output | 2 | 0 idle, 1 run, 2 tri-state shutdown, 3 fault hold |

## Verification
Every input reaction is due exactly three edges after the bench drives the input on a falling clock edge. Windowed results are due at fixed offsets from the high-side turn-off: refresh at REFRESH cycles and fault at FAULT cycles. Tri-state shutdown is due HOLDOFF_CYC cycles after the synchronized flag rises. The driver records each expected output together with its due cycle. The monitor compares it on that exact falling edge, and it also checks the cycle just before each transition, so an early or late change is reported.

// File: rtl/dts_pkg.sv
package dts_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_IDLE,
        ST_LS_FALL,
        ST_HS_ON,
        ST_WAIT_PH,
        ST_LS_REF,
        ST_LS_ON,
        ST_FAULT,
        ST_TRI
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_RUN   = 2'd1,
        MODE_TRI   = 2'd2,
        MODE_FAULT = 2'd3
    } seq_mode_e;

    typedef struct packed {
        seq_state_e st;
        seq_mode_e  mode;
        logic       hs;
        logic       ls;
        logic       pwm_prev;
    } seq_regs_t;

endpackage

// File: rtl/dts_sync.sv
module dts_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= async_i;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= '0;
            else        stg_q[i] <= stg_q[i-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/dts_timer.sv
module dts_timer #(
    parameter int MAX = 8,
    localparam int W  = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = W'(MAX);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                     cnt_d = '0;
        else if (inc && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/deadtime_sequencer.sv
module deadtime_sequencer #(
    parameter int CLK_MHZ     = 100,
    parameter int REFRESH_NS  = 250,
    parameter int FAULT_NS    = 2000,
    parameter int HOLDOFF_CYC = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm_in,
    input  logic       tri_win,
    input  logic       lg_low,
    input  logic       ph_low,
    input  logic       supply_ok,
    output logic       hs_en,
    output logic       ls_en,
    output logic [1:0] mode
);
    import dts_pkg::*;

    localparam int REF_CYC = CLK_MHZ * REFRESH_NS / 1000;
    localparam int FLT_CYC = CLK_MHZ * FAULT_NS / 1000;
    localparam int TW      = $clog2(FLT_CYC + 1);
    localparam int HW      = $clog2(HOLDOFF_CYC + 1);
    localparam logic [TW-1:0] REF_LIM  = TW'(REF_CYC - 1);
    localparam logic [TW-1:0] FLT_LIM  = TW'(FLT_CYC - 1);
    localparam logic [HW-1:0] HOLD_LIM = HW'(HOLDOFF_CYC - 1);

    // synchronized flags
    logic [4:0] raw_flags, s_flags;
    logic       s_pwm, s_lg, s_ph, s_tri, sup_s, lg_s;

    assign raw_flags = {supply_ok, tri_win, ph_low, lg_low, pwm_in};

    dts_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_flags),
        .sync_o (s_flags)
    );

    assign s_pwm = s_flags[0];
    assign s_lg  = s_flags[1];
    assign s_ph  = s_flags[2];
    assign s_tri = s_flags[3];
    assign sup_s = s_flags[4];
    assign lg_s  = s_lg;

    seq_regs_t seq_d, seq_q;

    // phase window timer: restarts on each high-side turn-off
    logic [TW-1:0] ph_cnt;
    logic          ph_clr, ph_inc;

    assign ph_clr = (seq_d.st == ST_WAIT_PH) && (seq_q.st != ST_WAIT_PH);
    assign ph_inc = (seq_q.st == ST_WAIT_PH) || (seq_q.st == ST_LS_REF);

    dts_timer #(.MAX(FLT_CYC)) u_ph_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ph_clr),
        .inc  (ph_inc),
        .cnt  (ph_cnt)
    );

    // tri-state holdoff timer: counts consecutive in-window cycles
    logic [HW-1:0] hold_cnt;

    dts_timer #(.MAX(HOLDOFF_CYC)) u_hold_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (~s_tri),
        .inc  (s_tri),
        .cnt  (hold_cnt)
    );

    logic rise, fall, tri_hit;

    always_comb begin
        seq_d          = seq_q;
        rise           = s_pwm & ~seq_q.pwm_prev;
        fall           = ~s_pwm & seq_q.pwm_prev;
        tri_hit        = s_tri && (hold_cnt >= HOLD_LIM);
        seq_d.pwm_prev = s_pwm;

        if (!sup_s) begin
            seq_d.st = ST_OFF;
        end else if (tri_hit) begin
            seq_d.st = ST_TRI;
        end else begin
            unique case (seq_q.st)
                ST_OFF:     seq_d.st = ST_IDLE;
                ST_IDLE: begin
                    if (rise)      seq_d.st = ST_LS_FALL;
                    else if (fall) seq_d.st = ST_WAIT_PH;
                end
                ST_LS_FALL: begin
                    if (fall)      seq_d.st = ST_WAIT_PH;
                    else if (s_lg) seq_d.st = ST_HS_ON;
                end
                ST_HS_ON: begin
                    if (fall)      seq_d.st = ST_WAIT_PH;
                end
                ST_WAIT_PH: begin
                    if (rise)                   seq_d.st = ST_LS_FALL;
                    else if (s_ph)              seq_d.st = ST_LS_ON;
                    else if (ph_cnt >= REF_LIM) seq_d.st = ST_LS_REF;
                end
                ST_LS_REF: begin
                    if (rise)                   seq_d.st = ST_LS_FALL;
                    else if (s_ph)              seq_d.st = ST_LS_ON;
                    else if (ph_cnt >= FLT_LIM) seq_d.st = ST_FAULT;
                end
                ST_LS_ON: begin
                    if (rise)      seq_d.st = ST_LS_FALL;
                end
                ST_FAULT: begin
                    if (rise)      seq_d.st = ST_LS_FALL;
                end
                ST_TRI:     seq_d.st = s_pwm ? ST_LS_FALL : ST_WAIT_PH;
                default:    seq_d.st = ST_OFF;
            endcase
        end

        seq_d.hs = (seq_d.st == ST_HS_ON);
        seq_d.ls = (seq_d.st == ST_LS_ON) || (seq_d.st == ST_LS_REF);

        unique case (seq_d.st)
            ST_OFF, ST_IDLE: seq_d.mode = MODE_IDLE;
            ST_TRI:          seq_d.mode = MODE_TRI;
            ST_FAULT:        seq_d.mode = MODE_FAULT;
            default:         seq_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st       <= ST_OFF;
            seq_q.mode     <= MODE_IDLE;
            seq_q.hs       <= 1'b0;
            seq_q.ls       <= 1'b0;
            seq_q.pwm_prev <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign hs_en = seq_q.hs;
    assign ls_en = seq_q.ls;
    assign mode  = seq_q.mode;

endmodule

// File: rtl/dts_checker.sv
module dts_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_en,
    input logic       ls_en,
    input logic [1:0] mode,
    input logic       sup_s,
    input logic       lg_s
);

    // R3: the two gate enables are never high together
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    // R1: a low synchronized supply flag turns everything off at the next edge
    p_supply_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_s |=> (!hs_en && !ls_en && mode == 2'd0));

    // R3: the high side rises only after the low gate was sensed low and the low side was off
    p_hs_after_lg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> ($past(lg_s) && !$past(ls_en)));

    // R4: the low side never rises directly out of a high-side cycle
    p_ls_after_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> !$past(hs_en));

    // R8: tri-state shutdown keeps both gates off
    p_tri_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (!hs_en && !ls_en));

    // R7: fault hold keeps both gates off
    p_fault_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> (!hs_en && !ls_en));

endmodule

bind deadtime_sequencer dts_checker u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .hs_en(hs_en),
    .ls_en(ls_en),
    .mode (mode),
    .sup_s(sup_s),
    .lg_s (lg_s)
);

// File: tb/sim_deadtime_sequencer.sv
module sim_deadtime_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_in = 1'b0, tri_win = 1'b0, lg_low = 1'b0, ph_low = 1'b0, supply_ok = 1'b0;
    logic       hs_en, ls_en;
    logic [1:0] mode;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        logic       hs;
        logic       ls;
        logic [1:0] md;
        string      req;
    } exp_t;

    exp_t sb[$];

    deadtime_sequencer u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_in   (pwm_in),
        .tri_win  (tri_win),
        .lg_low   (lg_low),
        .ph_low   (ph_low),
        .supply_ok(supply_ok),
        .hs_en    (hs_en),
        .ls_en    (ls_en),
        .mode     (mode)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // driver side: queue an expectation d cycles from now, kept in due order
    task automatic expect_out(int d, logic h, logic l, logic [1:0] m, string r);
        exp_t e;
        int   pos;
        e.due = cyc + d; e.hs = h; e.ls = l; e.md = m; e.req = r;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].due > e.due) begin
                pos = i;
                break;
            end
        end
        sb.insert(pos, e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare on the due falling edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.due < cyc || hs_en !== e.hs || ls_en !== e.ls || mode !== e.md) begin
                errors++;
                $display("FAIL %s cycle %0d: got hs=%b ls=%b mode=%0d, expected hs=%b ls=%b mode=%0d",
                         e.req, e.due, hs_en, ls_en, mode, e.hs, e.ls, e.md);
            end
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        expect_out(1, 0, 0, 0, "R1");          // reset state
        step(2);

        // R1: PWM activity with supply low does nothing
        pwm_in = 1'b1; expect_out(3, 0, 0, 0, "R1"); step(4);
        pwm_in = 1'b0; expect_out(3, 0, 0, 0, "R1"); step(6);

        // R2: supply returns, no edge, stays idle
        supply_ok = 1'b1; step(6);
        expect_out(1, 0, 0, 0, "R2"); step(2);

        // R3: rising edge, wait for low-gate flag
        pwm_in = 1'b1; expect_out(3, 0, 0, 1, "R3"); step(6);
        expect_out(1, 0, 0, 1, "R3"); step(2);
        lg_low = 1'b1; expect_out(2, 0, 0, 1, "R11"); expect_out(3, 1, 0, 1, "R3"); step(5);

        // R4: falling edge, low side follows phase flag
        pwm_in = 1'b0; expect_out(3, 0, 0, 1, "R4"); step(5);
        ph_low = 1'b1; expect_out(2, 0, 0, 1, "R11"); expect_out(3, 0, 1, 1, "R4"); step(6);

        // R5 / R6: phase never drops -> refresh then fault
        ph_low = 1'b0; step(2);
        pwm_in = 1'b1; expect_out(3, 0, 0, 1, "R10"); expect_out(4, 1, 0, 1, "R3"); step(8);
        pwm_in = 1'b0;
        expect_out(3, 0, 0, 1, "R4");
        expect_out(27, 0, 0, 1, "R5");
        expect_out(28, 0, 1, 1, "R5");
        expect_out(202, 0, 1, 1, "R6");
        expect_out(203, 0, 0, 3, "R6");
        step(210);

        // R7: fault holds until a rising edge
        ph_low = 1'b1; expect_out(6, 0, 0, 3, "R7"); step(8);
        pwm_in = 1'b1; expect_out(3, 0, 0, 1, "R7"); expect_out(4, 1, 0, 1, "R7"); step(8);

        // R10: edge mid-sequence restarts, windows restart
        ph_low = 1'b0; pwm_in = 1'b0; expect_out(3, 0, 0, 1, "R10"); step(5);
        pwm_in = 1'b1; expect_out(3, 0, 0, 1, "R10"); expect_out(4, 1, 0, 1, "R10"); step(8);
        pwm_in = 1'b0;
        expect_out(3, 0, 0, 1, "R10");
        expect_out(27, 0, 0, 1, "R10");
        expect_out(28, 0, 1, 1, "R10");
        step(30);
        ph_low = 1'b1; step(250);
        expect_out(1, 0, 1, 1, "R6");          // phase dropped in time: no fault
        step(2);

        // R8: short window ignored, full holdoff shuts down
        tri_win = 1'b1; step(10);
        tri_win = 1'b0; expect_out(12, 0, 1, 1, "R8"); step(14);
        tri_win = 1'b1; expect_out(17, 0, 1, 1, "R8"); expect_out(18, 0, 0, 2, "R8"); step(20);

        // R9: edges ignored during shutdown, resume from PWM level on release
        pwm_in = 1'b1; expect_out(6, 0, 0, 2, "R9"); step(4);
        pwm_in = 1'b0; step(4);
        pwm_in = 1'b1; step(4);
        tri_win = 1'b0; expect_out(3, 0, 0, 1, "R9"); expect_out(4, 1, 0, 1, "R9"); step(8);

        // R2 / R1: supply drop and return
        supply_ok = 1'b0; expect_out(3, 0, 0, 0, "R2"); step(5);
        pwm_in = 1'b0; expect_out(5, 0, 0, 0, "R1"); step(8);
        supply_ok = 1'b1; expect_out(3, 0, 0, 0, "R2"); expect_out(6, 0, 0, 0, "R2"); step(8);
        pwm_in = 1'b1; expect_out(3, 0, 0, 1, "R2"); expect_out(4, 1, 0, 1, "R2"); step(8);

        while (sb.size() > 0) step(1);
        step(2);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got run still active, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule